// File: doc/BRIEF.md
# Multiplexed Host Register Port

This block is the host-side access point of a bit-pattern tester. Address and data share one 8-bit bus. A strap input selects between two multiplexed bus timings. In Intel timing the block uses an active-low read strobe, an active-low write strobe and an address latch enable. In Motorola timing it uses a data strobe, a read/not-write line and an address strobe. The block latches the address and the write data, and keeps the writable setup bytes: pattern seed, pattern length, feedback tap, control and error insertion. It also returns read-only data: the bit count, the error count, the captured receive pattern and a status byte.

The bus strobes are modelled as synchronous inputs. They are sampled on `clk` and are assumed to be synchronized already. The pad tristate is split into `ad_out`, `ad_oe` and `ad_in`, and the open-drain interrupt pad is driven from `irq_pull`. The status byte holds event pulses from the datapath. A bit stays set until the host reads the status byte, and the interrupt stays active while any bit is set.

Top module: `host_reg_port`

## Requirements
- R1: The address is taken from `ad_in` in the clock cycle in which `ale` is first seen low after being high. Bus values during the data phase do not change the latched address.
- R2: With `bus_mode`=0 (Intel timing), a write happens when `wr_rw` (active-low write strobe) returns high while `cs_n` was low. It stores the byte last held on `ad_in` during the strobe.
- R3: With `bus_mode`=1 (Motorola timing), a write happens when `rd_ds` (data strobe, active high) falls while `wr_rw` is 0 and `cs_n` is low. Toggling `wr_rw` while the data strobe is low writes nothing.
- R4: While `cs_n` is high, no strobe writes a register and `ad_oe` stays 0.
- R5: `ad_oe` rises one clock after a qualified read strobe begins, and `ad_out` is valid at that point. `ad_oe` falls one clock after the strobe ends. In Intel timing the strobe ends when `rd_ds` (active-low read) goes high. In Motorola timing it ends when `rd_ds` goes low. `ad_oe` is never high outside a read.
- R6: The register map is:
  - 0x00–0x03: pattern seed, most significant byte at 0x00, presented on `pat_set`.
  - 0x04: length, presented on `pat_len`.
  - 0x05: tap, presented on `poly_tap`.
  - 0x06: control, presented on `pat_ctrl`.
  - 0x07: error insertion, presented on `err_ins`.
  - 0x08–0x0B: `bit_cnt`.
  - 0x0C–0x0F: `err_cnt`.
  - 0x10–0x13: `rx_pat`.
  - 0x14: status.
  
  Each multi-byte group is read most significant byte first.
- R7: Reads from any address at 0x15 or above return 0x00.
- R8: Writes to addresses 0x08 and above leave every writable register and the status byte unchanged.
- R9: A 1 on any bit of `status_evt` for one clock sets that status bit. `irq_pull` is 1 (pad pulled low) while any status bit is set.
- R10: Reading the status byte clears, when the read strobe ends, only the bits that the read returned. An event arriving during the read stays set.
- R11: After reset, all writable registers and the status byte are 0, and `ad_oe` and `irq_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Timing strap: 0 Intel, 1 Motorola |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable / address strobe; address taken on its fall |
| rd_ds | input | 1 | Intel: read strobe (active low). Motorola: data strobe (active high) |
| wr_rw | input | 1 | Intel: write strobe (active low). Motorola: 1 read, 0 write |
| ad_in | input | 8 | Bus value seen at the pads |
| ad_out | output | 8 | Read data to drive onto the bus |
| ad_oe | output | 1 | Bus drive enable |
| irq_pull | output | 1 | Drives the open-drain interrupt pad low when 1 |
| pat_set | output | 32 | Pattern seed bytes 0x00–0x03 |
| pat_len | output | 8 | Length register |
| poly_tap | output | 8 | Feedback tap register |
| pat_ctrl | output | 8 | Control register |
| err_ins | output | 8 | Error insertion register |
| bit_cnt | input | 32 | Bit count from the datapath |
| err_cnt | input | 32 | Error count from the datapath |
| rx_pat | input | 32 | Captured receive pattern |
| status_evt | input | 8 | One-clock status event pulses |

## Verification
A wrong latched address shows on the next data phase. The write lands in a neighbouring register, or the read returns that register's byte; the readback after the write exposes this. A strobe edge detector in the wrong state either commits a write with no strobe or drops one, and the next read of the target register shows it. A bad bus-enable state shows at `ad_oe` one clock after the read strobe changes. A wrong status latch shows on `irq_pull` in the clock after the event or after the read ends, and on the value returned by the next status read.

// File: rtl/host_port_pkg.sv
// Package: shared constants for the host register port.
// Assumes the writable file starts at address 0 with the seed bytes,
// followed by four single-byte setup registers in a fixed order.
package host_port_pkg;
    localparam int PSET_BASE = 0;
    localparam int OFS_LEN   = 0;
    localparam int OFS_TAP   = 1;
    localparam int OFS_CTRL  = 2;
    localparam int OFS_EINS  = 3;
    localparam int SETUP_REGS = 4;
endpackage

// File: rtl/hp_strobe_decode.sv
// Module: hp_strobe_decode
// Turns the raw multiplexed bus strobes into single-cycle events for either
// bus timing. Assumes all inputs are already synchronous to clk.
// Outputs: latched address, write data held during the strobe, a write
// pulse at strobe release, and read phase start/end pulses.
module hp_strobe_decode #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_mode,
    input  logic             cs_n,
    input  logic             ale,
    input  logic             rd_ds,
    input  logic             wr_rw,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] wdata_q,
    output logic             wr_stb,
    output logic             rd_phase,
    output logic             rd_start,
    output logic             rd_end
);
    logic wr_phase;
    logic wr_phase_q;
    logic rd_phase_q;
    logic ale_q;

    // Qualify the strobes by chip select and by the selected timing.
    always_comb begin
        if (bus_mode) begin
            rd_phase = !cs_n && rd_ds && wr_rw;
            wr_phase = !cs_n && rd_ds && !wr_rw;
        end else begin
            rd_phase = !cs_n && !rd_ds;
            wr_phase = !cs_n && !wr_rw;
        end
    end

    // Remember the previous phase levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q      <= 1'b0;
            rd_phase_q <= 1'b0;
            wr_phase_q <= 1'b0;
        end else begin
            ale_q      <= ale;
            rd_phase_q <= rd_phase;
            wr_phase_q <= wr_phase;
        end
    end

    // Capture the address when the address strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ale_q && !ale) begin
            addr_q <= ad_in;
        end
    end

    // Track the bus while the write strobe is active, so hold time at release is not needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (wr_phase) begin
            wdata_q <= ad_in;
        end
    end

    assign wr_stb   = wr_phase_q && !wr_phase;
    assign rd_start = rd_phase && !rd_phase_q;
    assign rd_end   = rd_phase_q && !rd_phase;

    // R4: a write pulse requires chip select in the previous cycle.
    p_write_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!cs_n));

    // R1: the address only moves after an address-strobe fall.
    p_addr_on_ale_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_q && !ale) |=> $stable(addr_q));
endmodule

// File: rtl/hp_regfile.sv
// Module: hp_regfile
// Writable setup bytes at addresses 0..NREG-1. Assumes a one-cycle write
// pulse from the strobe decoder. Writes to any higher address are dropped.
module hp_regfile #(
    parameter int BUS_W = 8,
    parameter int NREG  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [BUS_W-1:0]            addr,
    input  logic [BUS_W-1:0]            wdata,
    output logic [NREG-1:0][BUS_W-1:0]  regs
);
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            // Store one byte when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[i] <= '0;
                end else if (wr_stb && int'(addr) == i) begin
                    regs[i] <= wdata;
                end
            end
        end
    endgenerate

    // R8: writes outside the writable range change nothing here.
    p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && int'(addr) >= NREG) |=> $stable(regs));
endmodule

// File: rtl/hp_status_irq.sv
// Module: hp_status_irq
// Sticky status byte fed by one-cycle event pulses. A clear mask from the
// read path removes bits, and a new event wins over a clear. The interrupt
// request is active while any bit is set.
module hp_status_irq #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status_q,
    output logic              irq_pull
);
    // Latch events and apply the read-triggered clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | evt;
        end
    end

    assign irq_pull = |status_q;

    // R10: a set bit only goes away through the clear mask.
    p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

    // R9: the interrupt only rises after an event.
    p_irq_from_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> $past(|evt));
endmodule

// File: rtl/hp_read_mux.sv
// Module: hp_read_mux
// Selects the read byte for the latched address. The writable file comes
// first, then three multi-byte read-only groups (most significant byte
// first), then status. Everything above reads as zero.
module hp_read_mux #(
    parameter int BUS_W = 8,
    parameter int NREG  = 8,
    parameter int CNT_W = 32
) (
    input  logic [BUS_W-1:0]           addr,
    input  logic [NREG-1:0][BUS_W-1:0] regs,
    input  logic [CNT_W-1:0]           bit_cnt,
    input  logic [CNT_W-1:0]           err_cnt,
    input  logic [CNT_W-1:0]           rx_pat,
    input  logic [BUS_W-1:0]           status,
    output logic [BUS_W-1:0]           rdata,
    output logic                       is_status
);
    localparam int CNT_BYTES = CNT_W / BUS_W;
    localparam int BC_BASE   = NREG;
    localparam int EC_BASE   = BC_BASE + CNT_BYTES;
    localparam int RX_BASE   = EC_BASE + CNT_BYTES;
    localparam int ST_ADDR   = RX_BASE + CNT_BYTES;

    // Decode the address into one read byte.
    always_comb begin
        int a;
        int idx;
        a         = int'(addr);
        idx       = 0;
        rdata     = '0;
        is_status = 1'b0;
        if (a < NREG) begin
            rdata = regs[a];
        end else if (a < EC_BASE) begin
            idx   = CNT_BYTES - 1 - (a - BC_BASE);
            rdata = bit_cnt[idx*BUS_W +: BUS_W];
        end else if (a < RX_BASE) begin
            idx   = CNT_BYTES - 1 - (a - EC_BASE);
            rdata = err_cnt[idx*BUS_W +: BUS_W];
        end else if (a < ST_ADDR) begin
            idx   = CNT_BYTES - 1 - (a - RX_BASE);
            rdata = rx_pat[idx*BUS_W +: BUS_W];
        end else if (a == ST_ADDR) begin
            rdata     = status;
            is_status = 1'b1;
        end
    end
endmodule

// File: rtl/host_reg_port.sv
// Module: host_reg_port (top)
// Multiplexed host register port with a strap-selected bus timing.
// Assumes synchronous strobes. The read byte is snapshotted when the read
// strobe starts and driven until one clock after it ends. A status read
// clears the returned bits when the strobe ends.
module host_reg_port #(
    parameter int BUS_W  = 8,
    parameter int PSET_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_ds,
    input  logic              wr_rw,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic              irq_pull,
    output logic [PSET_W-1:0] pat_set,
    output logic [BUS_W-1:0]  pat_len,
    output logic [BUS_W-1:0]  poly_tap,
    output logic [BUS_W-1:0]  pat_ctrl,
    output logic [BUS_W-1:0]  err_ins,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [CNT_W-1:0]  err_cnt,
    input  logic [CNT_W-1:0]  rx_pat,
    input  logic [BUS_W-1:0]  status_evt
);
    import host_port_pkg::*;

    localparam int PSET_BYTES = PSET_W / BUS_W;
    localparam int NREG       = PSET_BYTES + SETUP_REGS;

    logic [BUS_W-1:0]           addr_q;
    logic [BUS_W-1:0]           wdata_q;
    logic                       wr_stb;
    logic                       rd_phase;
    logic                       rd_start;
    logic                       rd_end;
    logic [NREG-1:0][BUS_W-1:0] regs;
    logic [BUS_W-1:0]           rdata;
    logic                       rd_is_status;
    logic                       stat_rd_q;
    logic [BUS_W-1:0]           status_q;
    logic [BUS_W-1:0]           clr_mask;

    hp_strobe_decode #(.BUS_W(BUS_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
        .ale(ale), .rd_ds(rd_ds), .wr_rw(wr_rw), .ad_in(ad_in),
        .addr_q(addr_q), .wdata_q(wdata_q), .wr_stb(wr_stb),
        .rd_phase(rd_phase), .rd_start(rd_start), .rd_end(rd_end)
    );

    hp_regfile #(.BUS_W(BUS_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr_q),
        .wdata(wdata_q), .regs(regs)
    );

    hp_read_mux #(.BUS_W(BUS_W), .NREG(NREG), .CNT_W(CNT_W)) u_mux (
        .addr(addr_q), .regs(regs), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
        .rx_pat(rx_pat), .status(status_q), .rdata(rdata),
        .is_status(rd_is_status)
    );

    hp_status_irq #(.STAT_W(BUS_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(status_evt), .clr_mask(clr_mask),
        .status_q(status_q), .irq_pull(irq_pull)
    );

    // Snapshot the read byte at strobe start and follow the read phase with the drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_out    <= '0;
            ad_oe     <= 1'b0;
            stat_rd_q <= 1'b0;
        end else begin
            ad_oe <= rd_phase;
            if (rd_start) begin
                ad_out    <= rdata;
                stat_rd_q <= rd_is_status;
            end
        end
    end

    assign clr_mask = (rd_end && stat_rd_q) ? ad_out : '0;

    // Present the seed bytes, most significant at the lowest address.
    generate
        for (genvar i = 0; i < PSET_BYTES; i++) begin : g_pset
            assign pat_set[(PSET_BYTES-1-i)*BUS_W +: BUS_W] = regs[PSET_BASE+i];
        end
    endgenerate

    assign pat_len  = regs[PSET_BYTES+OFS_LEN];
    assign poly_tap = regs[PSET_BYTES+OFS_TAP];
    assign pat_ctrl = regs[PSET_BYTES+OFS_CTRL];
    assign err_ins  = regs[PSET_BYTES+OFS_EINS];

    // R5: the bus is released one clock after the read phase ends.
    p_bus_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_phase |=> !ad_oe);

    // R4: no drive without chip select in the cycle before.
    p_drive_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!cs_n));
endmodule

// File: tb/host_reg_port_tb_top.sv
module host_reg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_mode, cs_n, ale, rd_ds, wr_rw;
    logic [7:0]  ad_in, ad_out;
    logic        ad_oe, irq_pull;
    logic [31:0] pat_set;
    logic [7:0]  pat_len, poly_tap, pat_ctrl, err_ins;
    logic [31:0] bit_cnt, err_cnt, rx_pat;
    logic [7:0]  status_evt;
    int n_chk = 0;
    int n_err = 0;
    logic [7:0] wv [8];

    always #2 clk = ~clk;

    host_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .ale(ale),
        .rd_ds(rd_ds), .wr_rw(wr_rw), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .irq_pull(irq_pull), .pat_set(pat_set),
        .pat_len(pat_len), .poly_tap(poly_tap), .pat_ctrl(pat_ctrl),
        .err_ins(err_ins), .bit_cnt(bit_cnt), .err_cnt(err_cnt),
        .rx_pat(rx_pat), .status_evt(status_evt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic go_idle(logic m);
        @(negedge clk);
        bus_mode = m; cs_n = 1'b1; ale = 1'b0;
        rd_ds = m ? 1'b0 : 1'b1; wr_rw = 1'b1;
    endtask

    task automatic addr_phase(logic [7:0] a);
        @(negedge clk); cs_n = 1'b0; ale = 1'b1; ad_in = a;
        @(negedge clk); ale = 1'b0;
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        addr_phase(a);
        @(negedge clk); ad_in = d; wr_rw = 1'b0;
        if (bus_mode) rd_ds = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (bus_mode) rd_ds = 1'b0; else wr_rw = 1'b1;
        ad_in = 8'hC3;
        @(negedge clk); cs_n = 1'b1; wr_rw = 1'b1;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] d,
                            output logic oe_pre, output logic oe_on, output logic oe_post);
        addr_phase(a);
        @(negedge clk); ad_in = 8'h99; oe_pre = ad_oe;
        if (bus_mode) begin wr_rw = 1'b1; rd_ds = 1'b1; end else rd_ds = 1'b0;
        @(negedge clk); d = ad_out; oe_on = ad_oe;
        rd_ds = bus_mode ? 1'b0 : 1'b1;
        @(negedge clk); oe_post = ad_oe; cs_n = 1'b1;
    endtask

    function automatic logic [7:0] rd(logic [7:0] a);
        return 8'h00;
    endfunction

    task automatic read_chk(string tag, logic [7:0] a, logic [7:0] exp);
        logic [7:0] d; logic p, o, q;
        bus_read(a, d, p, o, q);
        chk(tag, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic t_reset();
        chk("R11 ad_oe after reset", {31'h0, ad_oe}, 32'h0);
        chk("R11 irq after reset", {31'h0, irq_pull}, 32'h0);
        chk("R11 pat_set after reset", pat_set, 32'h0);
        chk("R11 setup regs after reset", {pat_len, poly_tap, pat_ctrl, err_ins}, 32'h0);
    endtask

    task automatic t_intel_rw();
        go_idle(1'b0);
        for (int i = 0; i < 8; i++) begin
            wv[i] = 8'h3C ^ 8'(i * 37 + 1);
            bus_write(8'(i), wv[i]);
        end
        for (int i = 0; i < 8; i++) read_chk("R2 Intel readback", 8'(i), wv[i]);
        chk("R6 seed MSB first", pat_set, {wv[0], wv[1], wv[2], wv[3]});
        chk("R6 setup outputs", {pat_len, poly_tap, pat_ctrl, err_ins}, {wv[4], wv[5], wv[6], wv[7]});
    endtask

    task automatic t_addr_latch();
        go_idle(1'b0);
        bus_write(8'h05, 8'h06);
        wv[5] = 8'h06;
        read_chk("R1 addressed byte", 8'h05, 8'h06);
        read_chk("R1 data value not used as address", 8'h06, wv[6]);
    endtask

    task automatic t_moto();
        go_idle(1'b1);
        bus_write(8'h06, 8'h5A);
        wv[6] = 8'h5A;
        read_chk("R3 Motorola readback", 8'h06, 8'h5A);
        addr_phase(8'h06);
        @(negedge clk); ad_in = 8'hF0; wr_rw = 1'b0;
        @(negedge clk); wr_rw = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        read_chk("R3 rw toggle without strobe", 8'h06, 8'h5A);
    endtask

    task automatic t_cs();
        logic oe_any;
        go_idle(1'b0);
        @(negedge clk); ale = 1'b1; ad_in = 8'h04;
        @(negedge clk); ale = 1'b0;
        @(negedge clk); ad_in = 8'hEE; wr_rw = 1'b0;
        @(negedge clk); wr_rw = 1'b1;
        @(negedge clk); rd_ds = 1'b0; oe_any = 1'b0;
        for (int k = 0; k < 3; k++) begin @(negedge clk); oe_any |= ad_oe; end
        rd_ds = 1'b1;
        chk("R4 no drive with cs high", {31'h0, oe_any}, 32'h0);
        read_chk("R4 no write with cs high", 8'h04, wv[4]);
    endtask

    task automatic t_turnaround();
        logic [7:0] d; logic p, o, q;
        for (int m = 0; m < 2; m++) begin
            go_idle(m[0]);
            bus_read(8'h07, d, p, o, q);
            chk("R5 oe low before strobe", {31'h0, p}, 32'h0);
            chk("R5 oe high during read", {31'h0, o}, 32'h1);
            chk("R5 oe released after strobe end", {31'h0, q}, 32'h0);
            chk("R5 data valid with oe", {24'h0, d}, {24'h0, wv[7]});
        end
    endtask

    task automatic t_map();
        go_idle(1'b1);
        for (int i = 0; i < 4; i++) begin
            read_chk("R6 bit count byte", 8'(8 + i), bit_cnt[(3-i)*8 +: 8]);
            read_chk("R6 error count byte", 8'(12 + i), err_cnt[(3-i)*8 +: 8]);
            read_chk("R6 receive pattern byte", 8'(16 + i), rx_pat[(3-i)*8 +: 8]);
        end
    endtask

    task automatic t_unmapped();
        go_idle(1'b0);
        read_chk("R7 unmapped 0x15", 8'h15, 8'h00);
        read_chk("R7 unmapped 0x80", 8'h80, 8'h00);
        read_chk("R7 unmapped 0xFF", 8'hFF, 8'h00);
    endtask

    task automatic t_ro();
        go_idle(1'b0);
        bus_write(8'h09, 8'hEE);
        bus_write(8'h14, 8'hFF);
        bus_write(8'hC0, 8'h77);
        read_chk("R8 count byte not overwritten", 8'h09, bit_cnt[23:16]);
        chk("R8 seed unchanged", pat_set, {wv[0], wv[1], wv[2], wv[3]});
        chk("R8 setup unchanged", {pat_len, poly_tap, pat_ctrl, err_ins}, {wv[4], wv[5], wv[6], wv[7]});
        chk("R8 status not writable", {31'h0, irq_pull}, 32'h0);
        read_chk("R8 status still zero", 8'h14, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        go_idle(1'b0);
        @(negedge clk); status_evt = 8'h05;
        @(negedge clk); status_evt = 8'h00;
        chk("R9 irq after event", {31'h0, irq_pull}, 32'h1);
        addr_phase(8'h14);
        @(negedge clk); rd_ds = 1'b0;
        @(negedge clk); d = ad_out; rd_ds = 1'b1; status_evt = 8'h40;
        @(negedge clk); status_evt = 8'h00; cs_n = 1'b1;
        chk("R10 status read value", {24'h0, d}, 32'h05);
        chk("R10 irq held by late event", {31'h0, irq_pull}, 32'h1);
        read_chk("R10 only returned bits cleared", 8'h14, 8'h40);
        chk("R9 irq released when empty", {31'h0, irq_pull}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_mode = 1'b0; cs_n = 1'b1; ale = 1'b0;
        rd_ds = 1'b1; wr_rw = 1'b1; ad_in = 8'h00; status_evt = 8'h00;
        bit_cnt = 32'h11223344; err_cnt = 32'hA1B2C3D4; rx_pat = 32'h0F1E2D3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_intel_rw();
        t_addr_latch();
        t_moto();
        t_cs();
        t_turnaround();
        t_map();
        t_unmapped();
        t_ro();
        t_status();
        finish_run();
    end
endmodule